// File: doc/BRIEF.md
# Paired single-precision to integer truncating converter

This block takes a source word, reads the two single-precision floating-point values in its low 64 bits, and turns each one into a 32-bit two's-complement integer. Bits 31:0 of the source become bits 31:0 of the result, and bits 63:32 become bits 63:32. Each value is rounded toward zero. Any lane that holds a NaN or an infinity, or whose value does not fit in a signed 32-bit integer, is invalid. When the invalid-operation exception is masked, an invalid lane is written as the indefinite integer 0x80000000.

Each lane reports its own invalid flag and its own inexact flag. When the exception is unmasked and at least one lane is invalid, the block raises an exception strobe and leaves the result register unchanged. All outputs come from registers and appear one clock after the input strobe. The block sits on a datapath and is driven one operation per valid cycle. It has no storage beyond its output registers.

Top module: `fp2int_pair_trunc`

## Requirements
- R1: Only source bits 63:0 are converted. Source bits 31:0 give result bits 31:0, source bits 63:32 give result bits 63:32, and every source bit above 63 has no effect on any output.
- R2: A finite in-range value is converted to a signed 32-bit integer by dropping its fraction, rounding toward zero for both signs (1.5 gives 1, -1.5 gives 0xFFFFFFFF, -2.75 gives 0xFFFFFFFE).
- R3: A lane holding a NaN (quiet or signalling) or an infinity of either sign sets that lane's invalid flag. With the exception masked (`ie_mask_i`=1), that lane's result is 0x80000000.
- R4: A lane whose truncated value is at least +2^31, or below -2^31, is invalid and gives 0x80000000 when masked. The exact value -2^31 (0xCF000000) is valid, gives 0x80000000 and sets neither flag.
- R5: Zeros of either sign, denormals and every value with magnitude below 1.0 convert to 0.
- R6: A lane's inexact flag is 1 exactly when the lane is not invalid and the discarded fraction is nonzero. Denormals and nonzero values below 1.0 count as inexact; zeros do not.
- R7: With `ie_mask_i`=0 and at least one invalid lane, `ie_trap_o` is 1 for that result cycle and `result_o` keeps its previous value, while both flag vectors still report the new operation. With `ie_mask_i`=0 and no invalid lane, the result updates normally and `ie_trap_o` is 0.
- R8: `out_valid_o` is 1 in the cycle after `in_valid_i` is sampled high and 0 otherwise. Without `in_valid_i`, the result and both flag vectors hold their values and `ie_trap_o` is 0.
- R9: Synchronous active-high reset clears `out_valid_o`, `ie_trap_o`, `result_o` and both flag vectors to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation strobe |
| src_i | input | 128 | Source word; only bits 63:0 are used |
| ie_mask_i | input | 1 | 1 = invalid-operation exception masked |
| out_valid_o | output | 1 | Result strobe, one cycle after `in_valid_i` |
| result_o | output | 64 | Two packed signed 32-bit results |
| lane_invalid_o | output | 2 | Per-lane invalid flag, bit i for lane i |
| lane_inexact_o | output | 2 | Per-lane inexact flag, bit i for lane i |
| ie_trap_o | output | 1 | Unmasked invalid-operation exception |

## Verification
An unmasked exception and an inexact conversion can land in the same result cycle when one lane carries an infinity and the other carries a fractional value. The bench first loads a known result. It then applies an operand with that mix and `ie_mask_i` low. The cycle passes only if `ie_trap_o` is high, the result still equals the earlier value, the invalid flag names the bad lane, and the inexact flag names the other lane.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int INT_W  = 32;
  localparam int LANES  = 2;
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int PAIR_W = LANES * INT_W;
endpackage

// File: rtl/fpcvt_lane.sv
module fpcvt_lane #(
  parameter int EXP_W = fpcvt_pkg::EXP_W,
  parameter int MAN_W = fpcvt_pkg::MAN_W,
  parameter int INT_W = fpcvt_pkg::INT_W
) (
  input  logic [1+EXP_W+MAN_W-1:0] fp_i,
  output logic [INT_W-1:0]         val_o,
  output logic                     invalid_o,
  output logic                     inexact_o
);
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SH_W   = $clog2(INT_W);
  localparam int WIDE_W = MAN_W + INT_W;
  localparam logic [EXP_W-1:0] BIAS_E  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] LIMIT_E = EXP_W'(BIAS + INT_W - 1);
  localparam logic [INT_W-1:0] INDEF   = {1'b1, {(INT_W-1){1'b0}}};

  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [MAN_W-1:0]  frac;
  logic [EXP_W-1:0]  exp_off;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;
  logic [INT_W-1:0]  mag;
  logic              special, tiny, big, min_exact;

  assign sgn  = fp_i[FP_W-1];
  assign expo = fp_i[FP_W-2:MAN_W];
  assign frac = fp_i[MAN_W-1:0];

  assign special   = &expo;
  assign tiny      = expo < BIAS_E;
  assign big       = !special && (expo >= LIMIT_E);
  assign min_exact = sgn && (expo == LIMIT_E) && (frac == '0);

  assign exp_off = expo - BIAS_E;
  assign sh      = exp_off[SH_W-1:0];
  assign wide    = {{(INT_W-1){1'b0}}, 1'b1, frac} << sh;
  assign mag     = wide[WIDE_W-1:MAN_W];

  always_comb begin
    invalid_o = special || (big && !min_exact);
    inexact_o = 1'b0;
    val_o     = '0;
    if (special || big) begin
      val_o = INDEF;
    end else if (tiny) begin
      inexact_o = (expo != '0) || (frac != '0);
    end else begin
      val_o     = sgn ? (~mag + 1'b1) : mag;
      inexact_o = wide[MAN_W-1:0] != '0;
    end
  end
endmodule

// File: rtl/fpcvt_outreg.sv
module fpcvt_outreg #(
  parameter int LANES = fpcvt_pkg::LANES,
  parameter int INT_W = fpcvt_pkg::INT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid_i,
  input  logic                   ie_mask_i,
  input  logic [LANES*INT_W-1:0] vals_i,
  input  logic [LANES-1:0]       inv_i,
  input  logic [LANES-1:0]       inx_i,
  output logic                   out_valid_o,
  output logic [LANES*INT_W-1:0] result_o,
  output logic [LANES-1:0]       inv_o,
  output logic [LANES-1:0]       inx_o,
  output logic                   ie_trap_o
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic trap_now;
  assign trap_now = !ie_mask_i && (|inv_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      ie_trap_o   <= 1'b0;
      result_o    <= '0;
      inv_o       <= '0;
      inx_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      ie_trap_o   <= in_valid_i && trap_now;
      if (in_valid_i) begin
        inv_o <= inv_i;
        inx_o <= inx_i;
        if (!trap_now) result_o <= vals_i;
      end
    end
  end

  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> (!out_valid_o && !ie_trap_o && $stable(result_o)));
  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ie_trap_o |-> ($stable(result_o) && (|inv_o) && out_valid_o));
  // R6
  inx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_o & inx_o) == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R3
    indef_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !ie_trap_o && inv_o[g]) |-> (result_o[g*INT_W +: INT_W] == INDEF));
  end
endmodule

// File: rtl/fp2int_pair_trunc.sv
module fp2int_pair_trunc #(
  parameter int SRC_W = 128,
  parameter int EXP_W = fpcvt_pkg::EXP_W,
  parameter int MAN_W = fpcvt_pkg::MAN_W,
  parameter int INT_W = fpcvt_pkg::INT_W,
  parameter int LANES = fpcvt_pkg::LANES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid_i,
  input  logic [SRC_W-1:0]       src_i,
  input  logic                   ie_mask_i,
  output logic                   out_valid_o,
  output logic [LANES*INT_W-1:0] result_o,
  output logic [LANES-1:0]       lane_invalid_o,
  output logic [LANES-1:0]       lane_inexact_o,
  output logic                   ie_trap_o
);
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int USED_W = LANES * FP_W;

  logic [LANES*INT_W-1:0] vals;
  logic [LANES-1:0]       inv, inx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fpcvt_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_lane (
      .fp_i      (src_i[l*FP_W +: FP_W]),
      .val_o     (vals[l*INT_W +: INT_W]),
      .invalid_o (inv[l]),
      .inexact_o (inx[l])
    );
  end

  if (SRC_W > USED_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^src_i[SRC_W-1:USED_W];
  end

  fpcvt_outreg #(.LANES(LANES), .INT_W(INT_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .ie_mask_i   (ie_mask_i),
    .vals_i      (vals),
    .inv_i       (inv),
    .inx_i       (inx),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .inv_o       (lane_invalid_o),
    .inx_o       (lane_inexact_o),
    .ie_trap_o   (ie_trap_o)
  );
endmodule

// File: tb/tb_fp2int_pair_trunc.sv
module tb_fp2int_pair_trunc;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  // entry: {src[63:0], expected result[63:0], invalid[1:0], inexact[1:0]}
  localparam logic [131:0] VEC [NV] = '{
    {64'hBFC00000_3F800000, 64'hFFFFFFFF_00000001, 2'b00, 2'b10}, // R2
    {64'hC0300000_BFC00000, 64'hFFFFFFFE_FFFFFFFF, 2'b00, 2'b11}, // R2 R6
    {64'h42C80000_40300000, 64'h00000064_00000002, 2'b00, 2'b01}, // R2
    {64'h80000000_3F000000, 64'h00000000_00000000, 2'b00, 2'b01}, // R5
    {64'h00000001_7F800000, 64'h00000000_80000000, 2'b01, 2'b10}, // R3 R5
    {64'hFF800000_7FC00000, 64'h80000000_80000000, 2'b11, 2'b00}, // R3
    {64'h7F800001_4F000000, 64'h80000000_80000000, 2'b11, 2'b00}, // R3 R4
    {64'hCF000001_CF000000, 64'h80000000_80000000, 2'b10, 2'b00}, // R4
    {64'h4B000001_4EFFFFFF, 64'h00800001_7FFFFF80, 2'b00, 2'b00}, // R2 R4
    {64'hCAFFFFFF_4AFFFFFF, 64'hFF800001_007FFFFF, 2'b00, 2'b11}  // R2 R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [127:0] src = '0;
  logic ie_mask = 1'b1;
  logic out_valid, ie_trap;
  logic [63:0] result;
  logic [1:0] linv, linx;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fp2int_pair_trunc dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .src_i(src), .ie_mask_i(ie_mask),
    .out_valid_o(out_valid), .result_o(result), .lane_invalid_o(linv),
    .lane_inexact_o(linx), .ie_trap_o(ie_trap)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] s, input logic m);
    @(negedge clk);
    src = s; ie_mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 result", result, 64'd0);
    chk("R9 flags", {59'd0, ie_trap, linv, linx}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply({64'd0, VEC[i][131:68]}, 1'b1);
      chk("R8 out_valid", {63'd0, out_valid}, 64'd1);
      chk("R2/R3/R4/R5 result", result, VEC[i][67:4]);
      chk("R3/R4 invalid", {62'd0, linv}, {62'd0, VEC[i][3:2]});
      chk("R6 inexact", {62'd0, linx}, {62'd0, VEC[i][1:0]});
    end

    // R8 idle cycle holds result, out_valid low
    @(negedge clk);
    chk("R8 idle out_valid", {62'd0, out_valid, ie_trap}, 64'd0);
    chk("R8 idle result", result, VEC[NV-1][67:4]);
    chk("R8 idle flags", {60'd0, linv, linx}, {60'd0, VEC[NV-1][3:0]});

    // R1 upper source bits ignored
    apply({64'hFFFF_FFFF_7F80_0000, 64'h3F800000_40300000}, 1'b1);
    chk("R1 lanes", result, 64'h00000001_00000002);
    chk("R1 flags", {60'd0, linv, linx}, {60'd0, 2'b00, 2'b01});

    // R7 unmasked with no invalid lane updates normally
    apply({64'd0, 64'h3F800000_3F800000}, 1'b0);
    chk("R7 no-trap result", result, 64'h00000001_00000001);
    chk("R7 no-trap strobe", {63'd0, ie_trap}, 64'd0);

    // R7 trap coinciding with inexact on the other lane
    apply({64'd0, 64'h3FC00000_7F800000}, 1'b0);
    chk("R7 trap strobe", {63'd0, ie_trap}, 64'd1);
    chk("R7 result held", result, 64'h00000001_00000001);
    chk("R7 invalid", {62'd0, linv}, 64'd1);
    chk("R7 inexact", {62'd0, linx}, 64'd2);
    @(negedge clk);
    chk("R7 trap clears", {63'd0, ie_trap}, 64'd0);

    // R9 reset after activity
    apply({64'd0, 64'hC0300000_BFC00000}, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset", {result[61:0], out_valid, |{linv, linx, ie_trap}}, 64'd0);
    rst = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule